// File: doc/BRIEF.md
# External Bus Sizing Controller

This block sits between internal bus masters and a 16-bit external data bus. A master hands over one transfer at a time: an address, a size (byte, word or longword), a direction and, for writes, the data. The block turns that transfer into one or more external bus cycles and returns read data once the last cycle is over. Each external area is set up on its own as 8-bit space or 16-bit space, and as a 2-state area or a 3-state area with extra wait states. The block places every byte on the correct half of the external data bus for the area it addresses.

A single strobe pin is shared. After reset it behaves as a plain address strobe on every cycle. Once its enable is set, it pulses only on cycles whose address falls in a programmable I/O window. The window always begins at offset F000 of the top 64 KiB page and ends at one of four limits.

The request side is a valid/ready stream. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A master that holds `req_valid` high waits, with its fields held steady, until `req_ready` returns. There is no back-pressure on the result: `done` is a single-cycle pulse and the master must take `rdata` in that cycle.

Top module: `bus_sizer`

## Requirements
- R1: `req_ready` is 1 in the idle state and 0 from the cycle after acceptance until the transfer ends. `done` pulses for exactly one cycle, one cycle after the last state of the last external cycle. `req_ready` is 1 again in the cycle after `done`.
- R2: In an 8-bit area, only the upper lane (bits 15..8) is used in every cycle, and `ext_wr_lo_n` stays 1. A byte takes 1 cycle, a word 2 cycles and a longword 4 cycles. The cycles run at addresses A, A+1, and so on.
- R3: Split transfers are big-endian. The first cycle carries the most significant byte or halfword of `req_wdata`. Read data is assembled right-aligned in `rdata`: the byte in [7:0], the word in [15:0], the longword in [31:0].
- R4: In a 16-bit area, address bit 0 is cleared for word and longword transfers. A word is one cycle on both lanes. A longword is two cycles on both lanes, at the aligned address and then the aligned address + 2.
- R5: In a 16-bit area, a byte at an even address uses only the upper lane. A byte at an odd address uses only the lower lane, with its data on bits 7..0.
- R6: Each external cycle lasts 2 states, or 3 + W states when the area's slow bit is set, where W is the area's 2-bit wait count. The first state of each cycle drives the address with all strobes at 1. The remaining states drive `ext_rd_n` (read), or the lane write strobes (write), to 0.
- R7: The area index is the top log2(AREAS) address bits. The area's width, slow and wait settings are sampled when a request is accepted. Changes to them during a transfer have no effect on that transfer.
- R8: With the I/O enable at 0, `ext_strb_n` is 0 in every non-first state of every cycle. With it at 1, `ext_strb_n` is 0 only in those states of cycles whose address lies in the window.
- R9: An address lies in the window when its bits above bit 11 are all ones and its low 12 bits are at most 03F, 0FF, 3FF or 7FF, for window codes 00, 01, 10 and 11. Each cycle of a split transfer is judged on its own address.
- R10: Reset sets the window code to 11 and the I/O enable to 0. After reset, `req_ready` is 1, `done` is 0 and all strobes are 1. `cfg_win_ld` and `cfg_en_ld` each load their own field.
- R11: Size code 11 is handled as a longword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Transfer start address |
| req_size | input | 2 | 00 byte, 01 word, 10/11 longword |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| done | output | 1 | Transfer finished (one-cycle pulse) |
| rdata | output | 32 | Read data, valid while done is 1 |
| cfg_wide | input | AREAS | Per area: 1 selects 16-bit space |
| cfg_slow | input | AREAS | Per area: 1 selects 3-state cycles |
| cfg_wait | input | 2*AREAS | Per area: wait count, area n at bits [2n+1:2n] |
| cfg_win_ld | input | 1 | Load the window code |
| cfg_win_d | input | 2 | New window code |
| cfg_en_ld | input | 1 | Load the I/O enable |
| cfg_en_d | input | 1 | New I/O enable |
| ext_addr | output | ADDR_W | External address, 0 when idle |
| ext_strb_n | output | 1 | Shared address / I/O-select strobe, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_hi_n | output | 1 | Upper lane write strobe, active low |
| ext_wr_lo_n | output | 1 | Lower lane write strobe, active low |
| ext_doe | output | 1 | Write data drive enable |
| ext_dout | output | 16 | Write data to the external bus |
| ext_din | input | 16 | Read data from the external bus |

## Verification
The bench builds the block with its default parameters: a 24-bit address and eight areas. With eight areas, narrow, wide, fast and slow areas can all be set up together, including every wait count the slow areas use. The 24-bit space puts area 7 on the top page, so the I/O window can be reached. The bench covers all four window limits from both sides, and one longword whose two cycles fall on opposite sides of a limit.

// File: rtl/bus_sizer_pkg.sv
package bus_sizer_pkg;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'd0,
    FSM_BUS  = 2'd1,
    FSM_DONE = 2'd2
  } fsm_e;

  // last in-window offset within the F000 page segment
  function automatic logic [11:0] win_limit(input logic [1:0] code);
    logic [11:0] lim;
    case (code)
      2'b00:   lim = 12'h03F;
      2'b01:   lim = 12'h0FF;
      2'b10:   lim = 12'h3FF;
      default: lim = 12'h7FF;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/bus_sizer_plan.sv
// Per-cycle plan: beat count, cycle address, lanes and write data for a beat.
module bus_sizer_plan #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [1:0]        size,
  input  logic              wide,
  input  logic [1:0]        beat,
  input  logic [31:0]       wdata,
  output logic [1:0]        nb_m1,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              use_hi,
  output logic              use_lo,
  output logic [15:0]       dout
);
  logic [1:0]        bidx;
  logic              widx;
  logic [ADDR_W-1:0] aligned;

  always_comb begin
    aligned  = {base_addr[ADDR_W-1:1], 1'b0};
    nb_m1    = 2'd0;
    cyc_addr = base_addr;
    use_hi   = 1'b1;
    use_lo   = 1'b0;
    dout     = 16'h0000;
    bidx     = 2'd0;
    widx     = 1'b0;
    if (!wide) begin
      // narrow space: one byte per cycle, upper lane, MSB first
      case (size)
        2'b00:   nb_m1 = 2'd0;
        2'b01:   nb_m1 = 2'd1;
        default: nb_m1 = 2'd3;
      endcase
      bidx     = nb_m1 - beat;
      cyc_addr = base_addr + ADDR_W'(beat);
      dout     = {wdata[{bidx, 3'b000} +: 8], 8'h00};
    end else if (size == 2'b00) begin
      use_hi = ~base_addr[0];
      use_lo = base_addr[0];
      dout   = base_addr[0] ? {8'h00, wdata[7:0]} : {wdata[7:0], 8'h00};
    end else begin
      nb_m1    = size[1] ? 2'd1 : 2'd0;
      widx     = nb_m1[0] & ~beat[0];
      use_lo   = 1'b1;
      cyc_addr = aligned + ADDR_W'({beat, 1'b0});
      dout     = widx ? wdata[31:16] : wdata[15:0];
    end
  end
endmodule

// File: rtl/bus_sizer_timer.sv
// State counter inside one external cycle.
module bus_sizer_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       slow,
  input  logic [1:0] waits,
  output logic [2:0] st,
  output logic       last
);
  logic [2:0] len_m1;

  assign len_m1 = slow ? (3'd2 + {1'b0, waits}) : 3'd1;
  assign last   = run && (st == len_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            st <= 3'd0;
    else if (!run || last) st <= 3'd0;
    else                   st <= st + 3'd1;
  end

  // R6
  st_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (st <= len_m1));
endmodule

// File: rtl/bus_sizer_iowin.sv
// I/O window settings and address match.
module bus_sizer_iowin import bus_sizer_pkg::*; #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_ld,
  input  logic [1:0]        win_d,
  input  logic              en_ld,
  input  logic              en_d,
  input  logic [ADDR_W-1:0] addr,
  output logic              io_en,
  output logic              hit
);
  logic [1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 2'b11;
      io_en <= 1'b0;
    end else begin
      if (win_ld) win_q <= win_d;
      if (en_ld)  io_en <= en_d;
    end
  end

  assign hit = (&addr[ADDR_W-1:12]) && (addr[11:0] <= win_limit(win_q));

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ld |=> $stable(io_en));
  // R10
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_ld |=> $stable(win_q));
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer import bus_sizer_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int AREAS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_write,
  input  logic [31:0]          req_wdata,
  output logic                 done,
  output logic [31:0]          rdata,
  input  logic [AREAS-1:0]     cfg_wide,
  input  logic [AREAS-1:0]     cfg_slow,
  input  logic [2*AREAS-1:0]   cfg_wait,
  input  logic                 cfg_win_ld,
  input  logic [1:0]           cfg_win_d,
  input  logic                 cfg_en_ld,
  input  logic                 cfg_en_d,
  output logic [ADDR_W-1:0]    ext_addr,
  output logic                 ext_strb_n,
  output logic                 ext_rd_n,
  output logic                 ext_wr_hi_n,
  output logic                 ext_wr_lo_n,
  output logic                 ext_doe,
  output logic [15:0]          ext_dout,
  input  logic [15:0]          ext_din
);
  localparam int AREA_W = (AREAS > 1) ? $clog2(AREAS) : 1;

  fsm_e              fsm_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              wr_q;
  logic [31:0]       wd_q;
  logic              wide_q, slow_q;
  logic [1:0]        wait_q;
  logic [1:0]        beat_q;
  logic [31:0]       rbuf_q;

  logic              busy, active;
  logic [AREA_W-1:0] area_sel;
  logic [1:0]        nb_m1;
  logic [ADDR_W-1:0] cyc_addr;
  logic              use_hi, use_lo;
  logic [15:0]       pdout;
  logic [2:0]        st;
  logic              last;
  logic              io_en, hit;
  logic [7:0]        cap8;
  logic [31:0]       rbuf_nx;

  assign busy     = (fsm_q == FSM_BUS);
  assign active   = busy && (st != 3'd0);
  assign area_sel = req_addr[ADDR_W-1 -: AREA_W];

  bus_sizer_plan #(.ADDR_W(ADDR_W)) u_plan (
    .base_addr (addr_q),
    .size      (size_q),
    .wide      (wide_q),
    .beat      (beat_q),
    .wdata     (wd_q),
    .nb_m1     (nb_m1),
    .cyc_addr  (cyc_addr),
    .use_hi    (use_hi),
    .use_lo    (use_lo),
    .dout      (pdout)
  );

  bus_sizer_timer u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .slow  (slow_q),
    .waits (wait_q),
    .st    (st),
    .last  (last)
  );

  bus_sizer_iowin #(.ADDR_W(ADDR_W)) u_iowin (
    .clk    (clk),
    .rst_n  (rst_n),
    .win_ld (cfg_win_ld),
    .win_d  (cfg_win_d),
    .en_ld  (cfg_en_ld),
    .en_d   (cfg_en_d),
    .addr   (cyc_addr),
    .io_en  (io_en),
    .hit    (hit)
  );

  // read assembly: shift in one byte or one halfword per cycle
  always_comb begin
    cap8    = (wide_q && use_lo) ? ext_din[7:0] : ext_din[15:8];
    rbuf_nx = (wide_q && size_q != 2'b00) ? {rbuf_q[15:0], ext_din}
                                          : {rbuf_q[23:0], cap8};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= FSM_IDLE;
      addr_q <= '0;
      size_q <= 2'b00;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      wide_q <= 1'b0;
      slow_q <= 1'b0;
      wait_q <= 2'b00;
      beat_q <= 2'd0;
      rbuf_q <= '0;
    end else begin
      case (fsm_q)
        FSM_IDLE: if (req_valid) begin
          fsm_q  <= FSM_BUS;
          addr_q <= req_addr;
          size_q <= req_size;
          wr_q   <= req_write;
          wd_q   <= req_wdata;
          wide_q <= cfg_wide[area_sel];
          slow_q <= cfg_slow[area_sel];
          wait_q <= cfg_wait[{area_sel, 1'b0} +: 2];
          beat_q <= 2'd0;
          rbuf_q <= '0;
        end
        FSM_BUS: if (last) begin
          if (!wr_q) rbuf_q <= rbuf_nx;
          if (beat_q == nb_m1) fsm_q <= FSM_DONE;
          else                 beat_q <= beat_q + 2'd1;
        end
        default: fsm_q <= FSM_IDLE;
      endcase
    end
  end

  assign req_ready   = (fsm_q == FSM_IDLE);
  assign done        = (fsm_q == FSM_DONE);
  assign rdata       = rbuf_q;
  assign ext_addr    = busy ? cyc_addr : '0;
  assign ext_rd_n    = ~(active && !wr_q);
  assign ext_wr_hi_n = ~(active && wr_q && use_hi);
  assign ext_wr_lo_n = ~(active && wr_q && use_lo);
  assign ext_doe     = busy && wr_q;
  assign ext_dout    = (busy && wr_q) ? pdout : 16'h0000;
  assign ext_strb_n  = ~(active && (!io_en || hit));

  // R1
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !done));
  // R2
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wide_q) |-> (ext_wr_lo_n && ext_dout[7:0] == 8'h00));
  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && (!ext_wr_hi_n || !ext_wr_lo_n)));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ext_strb_n && ext_rd_n && ext_wr_hi_n && ext_wr_lo_n));
endmodule

// File: tb/test_bus_sizer.sv
`timescale 1ns/1ps
module test_bus_sizer;
  localparam int AW = 24;
  localparam int AR = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_write, done;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [31:0]   req_wdata, rdata;
  logic [AR-1:0] cfg_wide, cfg_slow;
  logic [2*AR-1:0] cfg_wait;
  logic          cfg_win_ld, cfg_en_ld, cfg_en_d;
  logic [1:0]    cfg_win_d;
  logic [AW-1:0] ext_addr;
  logic          ext_strb_n, ext_rd_n, ext_wr_hi_n, ext_wr_lo_n, ext_doe;
  logic [15:0]   ext_dout, ext_din;

  bus_sizer #(.ADDR_W(AW), .AREAS(AR)) i_bus_sizer (.*);

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign ext_din = {mb(ext_addr), mb(ext_addr | 24'd1)};

  int errors = 0;
  int checks = 0;
  logic [1:0] m_win = 2'b11;
  bit m_en = 1'b0;

  task automatic ceq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [AW-1:0] a, input logic [1:0] code);
    logic [11:0] lim;
    case (code)
      2'b00: lim = 12'h03F;
      2'b01: lim = 12'h0FF;
      2'b10: lim = 12'h3FF;
      default: lim = 12'h7FF;
    endcase
    return (a[23:12] == 12'hFFF) && (a[11:0] <= lim);
  endfunction

  task automatic set_win(input logic [1:0] code);
    @(negedge clk); cfg_win_d = code; cfg_win_ld = 1'b1;
    @(negedge clk); cfg_win_ld = 1'b0; m_win = code;
  endtask

  task automatic set_en(input bit en);
    @(negedge clk); cfg_en_d = en; cfg_en_ld = 1'b1;
    @(negedge clk); cfg_en_ld = 1'b0; m_en = en;
  endtask

  task automatic xfer(input logic [AW-1:0] a, input logic [1:0] sz, input bit wr,
                      input logic [31:0] wd, input bit flip, input string tag);
    int ar;
    bit wide, slow;
    int wt, len, nbytes, nb;
    logic [AW-1:0] base, ea;
    logic [31:0] exp_rd;
    bit hi, lo, act;
    logic [15:0] ed;
    ar     = int'(a[23:21]);
    wide   = cfg_wide[ar];
    slow   = cfg_slow[ar];
    wt     = int'(cfg_wait[2*ar +: 2]);
    len    = slow ? 3 + wt : 2;
    nbytes = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    nb     = !wide ? nbytes : (sz == 2'b00) ? 1 : nbytes / 2;
    base   = (wide && sz != 2'b00) ? {a[23:1], 1'b0} : a;
    exp_rd = 32'h0;
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    ceq({tag, " R1 ready idle"}, {31'b0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) begin cfg_wide[ar] = ~cfg_wide[ar]; cfg_slow[ar] = ~cfg_slow[ar]; end
    for (int b = 0; b < nb; b++) begin
      if (!wide) begin
        ea = a + AW'(b); hi = 1'b1; lo = 1'b0;
        ed = {wd[8*(nbytes-1-b) +: 8], 8'h00};
        exp_rd = (exp_rd << 8) | {24'h0, mb(ea)};
      end else if (sz == 2'b00) begin
        ea = a; hi = ~a[0]; lo = a[0];
        ed = a[0] ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00};
        exp_rd = {24'h0, mb(a)};
      end else begin
        ea = base + AW'(2*b); hi = 1'b1; lo = 1'b1;
        ed = wd[16*(nb-1-b) +: 16];
        exp_rd = (exp_rd << 16) | {16'h0, mb(ea), mb(ea + 24'd1)};
      end
      for (int s = 0; s < len; s++) begin
        act = (s != 0);
        ceq({tag, " R2 R4 cycle address"}, 32'(ext_addr), 32'(ea));
        ceq({tag, " R6 rd strobe"}, {31'b0, ext_rd_n}, {31'b0, ~(act && !wr)});
        ceq({tag, " R5 R6 upper write strobe"}, {31'b0, ext_wr_hi_n}, {31'b0, ~(act && wr && hi)});
        ceq({tag, " R2 R5 lower write strobe"}, {31'b0, ext_wr_lo_n}, {31'b0, ~(act && wr && lo)});
        ceq({tag, " R8 R9 shared strobe"}, {31'b0, ext_strb_n},
            {31'b0, ~(act && (!m_en || in_win(ea, m_win)))});
        if (wr) ceq({tag, " R3 write lanes"}, {16'h0, ext_dout}, {16'h0, ed});
        ceq({tag, " R1 no done while busy"}, {30'b0, done, req_ready}, 32'd0);
        @(negedge clk);
      end
    end
    ceq({tag, " R1 done pulse"}, {30'b0, done, req_ready}, 32'd2);
    if (!wr) ceq({tag, " R3 read assembly"}, rdata, exp_rd);
    if (flip) begin cfg_wide[ar] = ~cfg_wide[ar]; cfg_slow[ar] = ~cfg_slow[ar]; end
    @(negedge clk);
    ceq({tag, " R1 ready after done"}, {30'b0, done, req_ready}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = 2'b00;
    req_write = 1'b0; req_wdata = '0;
    cfg_wide = 8'b1000_1010; cfg_slow = 8'b1000_1100; cfg_wait = 16'h00E0;
    cfg_win_ld = 1'b0; cfg_win_d = 2'b00; cfg_en_ld = 1'b0; cfg_en_d = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    ceq("R10 reset ready/done", {30'b0, done, req_ready}, 32'd1);
    ceq("R10 reset strobes", {28'b0, ext_strb_n, ext_rd_n, ext_wr_hi_n, ext_wr_lo_n}, 32'hF);

    xfer(24'h000011, 2'b00, 1'b0, 32'h0, 1'b0, "R2 narrow byte rd");
    xfer(24'h000021, 2'b01, 1'b1, 32'h0000_A1B2, 1'b0, "R3 narrow word wr");
    xfer(24'h000100, 2'b10, 1'b0, 32'h0, 1'b0, "R2 narrow long rd");
    xfer(24'h400003, 2'b10, 1'b1, 32'h1122_3344, 1'b0, "R6 narrow slow long wr");
    xfer(24'h200010, 2'b00, 1'b0, 32'h0, 1'b0, "R5 wide even byte rd");
    xfer(24'h200011, 2'b00, 1'b0, 32'h0, 1'b0, "R5 wide odd byte rd");
    xfer(24'h200013, 2'b00, 1'b1, 32'h0000_0077, 1'b0, "R5 wide odd byte wr");
    xfer(24'h200012, 2'b00, 1'b1, 32'h0000_0099, 1'b0, "R5 wide even byte wr");
    xfer(24'h200021, 2'b01, 1'b0, 32'h0, 1'b0, "R4 wide word rd");
    xfer(24'h200040, 2'b01, 1'b1, 32'h0000_BEEF, 1'b0, "R4 wide word wr");
    xfer(24'h600040, 2'b10, 1'b0, 32'h0, 1'b0, "R4 wide slow long rd");
    xfer(24'h600046, 2'b10, 1'b1, 32'hCAFE_F00D, 1'b0, "R6 wide slow long wr");
    xfer(24'h200050, 2'b11, 1'b0, 32'h0, 1'b0, "R11 size 11 rd");
    xfer(24'h000030, 2'b01, 1'b0, 32'h0, 1'b1, "R7 config change mid transfer");
    xfer(24'h200060, 2'b10, 1'b1, 32'h0102_0304, 1'b1, "R7 config change wide");
    xfer(24'hFFF100, 2'b01, 1'b0, 32'h0, 1'b0, "R8 strobe as address strobe");
    xfer(24'h000040, 2'b00, 1'b0, 32'h0, 1'b0, "R8 strobe low area");
    set_en(1'b1);
    xfer(24'hFFF7FE, 2'b01, 1'b0, 32'h0, 1'b0, "R10 reset code upper end");
    xfer(24'hFFF800, 2'b01, 1'b0, 32'h0, 1'b0, "R9 past code 11 end");
    xfer(24'hFFF000, 2'b00, 1'b1, 32'h0000_0042, 1'b0, "R9 window start");
    set_win(2'b00);
    xfer(24'hFFF03C, 2'b10, 1'b0, 32'h0, 1'b0, "R9 code 00 inside");
    xfer(24'hFFF03E, 2'b10, 1'b0, 32'h0, 1'b0, "R9 long across limit");
    xfer(24'hFFE000, 2'b01, 1'b0, 32'h0, 1'b0, "R9 below F000");
    xfer(24'h7FF000, 2'b01, 1'b0, 32'h0, 1'b0, "R9 not top page");
    xfer(24'h000010, 2'b00, 1'b0, 32'h0, 1'b0, "R8 no strobe outside");
    set_win(2'b01);
    xfer(24'hFFF0FF, 2'b00, 1'b1, 32'h0000_0005, 1'b0, "R9 code 01 inside");
    xfer(24'hFFF100, 2'b00, 1'b0, 32'h0, 1'b0, "R9 code 01 outside");
    set_win(2'b10);
    xfer(24'hFFF3FE, 2'b01, 1'b0, 32'h0, 1'b0, "R9 code 10 inside");
    xfer(24'hFFF400, 2'b01, 1'b0, 32'h0, 1'b0, "R9 code 10 outside");
    set_en(1'b0);
    xfer(24'h200070, 2'b01, 1'b0, 32'h0, 1'b0, "R8 enable cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog act=%h exp=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule